// File: doc/BRIEF.md
# Receive Descriptor DMA Engine

This block takes received Ethernet frames from a byte stream and places them in host memory. Where each frame goes is set by a ring of four-word receive descriptors that the host builds in that memory. Descriptor and data traffic both use one word-addressed memory master port. It has a fixed read latency and accepts one access per cycle. The host gives a base address for the ring, a run level that starts and stops the engine, and a one-cycle poll strobe. A three-bit state code shows what the engine is doing.

Each descriptor carries an ownership bit. When the bit says the engine owns the descriptor, the engine stores the next frame in that descriptor's buffer. It then writes back the length and the error status and returns the descriptor to the host. The next descriptor comes from one of three places: the ring base, a chained pointer, or the word that follows the current descriptor. If the engine finds a descriptor that the host still owns, it suspends and waits for a poll strobe. A frame that arrives when the engine is not waiting for one is discarded whole and counted.

Top module: `rxd_dma`

## Requirements
- R1: After reset the state code is 0 (stopped), the missed-frame count is 0 and the memory port is idle.
- R2: While stopped, a high run level makes the engine fetch the descriptor at the base address; the state shows 1 while it fetches. A low run level returns the engine to state 0 from waiting, suspended or fetching, and after the close of a frame in progress.
- R3: A fetched descriptor whose word 0 bit 31 is 0 belongs to the host. The engine then enters state 4 and makes no memory access until a poll strobe. The poll strobe makes it re-fetch the same descriptor.
- R4: A descriptor with bit 31 set moves the engine to state 3. The following frame is written from the word address in descriptor word 2 onward, four bytes to a word, with the first byte in bits 7:0. Lanes after the frame's last byte in the final word are zero. The state shows 7 while the frame body arrives.
- R5: At the end of a frame the engine shows state 5 and rewrites word 0 of the descriptor. The new word 0 has bit 31 clear, bits 9 and 8 set, the number of stored bytes in bits 29:16, bit 15 as the error flag, and all other bits zero.
- R6: Descriptor word 1 bits 11:0 give the buffer size in bytes. A longer frame stores exactly that many bytes, drops the rest, writes nothing past the buffer, and sets bit 15 with a length equal to the size.
- R7: After the close, the next descriptor address depends on descriptor word 1. If bit 15 is set, it is the base address. Otherwise, if bit 14 is set, it is taken from word 3. Otherwise it is the current address plus 4.
- R8: A frame whose first byte arrives when the engine is not in state 3 with run high is dropped whole. Nothing is written, and the missed-frame count goes up by one (wrapping).
- R9: A poll strobe has no effect outside state 4.
- R10: The state code only takes the values 0, 1, 3, 4, 5 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | AW | Word address of the first descriptor |
| run | input | 1 | High to run, low to stop |
| poll | input | 1 | One-cycle poll-demand strobe |
| rx_valid | input | 1 | A frame byte is present |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Marks the last byte of a frame |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | High for write, low for read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| dma_state | output | 3 | Process state code |
| missed_cnt | output | CW | Count of dropped frames |

## Verification
Two of the engine's functions can fall in the same cycle. A frame can start in the same cycle as a poll strobe while the engine waits, and a frame can start in the cycle that run falls or while the engine suspends. In the random phase the bench pulses poll together with the first byte of about a third of the frames. It judges the outcome by exact buffer contents, sentinel words past the buffer and the written-back status word. Directed cases start frames while the engine is suspended and while it is stopped. They check that the buffer is still untouched and that the missed count has stepped.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [2:0] {
    ST_STOP  = 3'd0,
    ST_FETCH = 3'd1,
    ST_WAIT  = 3'd3,
    ST_SUSP  = 3'd4,
    ST_CLOSE = 3'd5,
    ST_WRITE = 3'd7
  } rx_state_e;

  localparam int DW        = 32;
  localparam int LANES     = DW / 8;
  localparam int OWN_BIT   = 31;
  localparam int ERR_BIT   = 15;
  localparam int FIRST_BIT = 9;
  localparam int LAST_BIT  = 8;
  localparam int LEN_LSB   = 16;
  localparam int LEN_W     = 14;
  localparam int SIZE_W    = 12;
  localparam int CHAIN_BIT = 14;
  localparam int EOR_BIT   = 15;
  localparam int DESC_WORDS = 4;
endpackage

// File: rtl/rxd_ingress.sv
// Tracks frame boundaries on the input stream and counts dropped frames.
module rxd_ingress #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic          rx_last,
  input  logic          accept,
  output logic          frame_start,
  output logic [CW-1:0] missed
);
  logic in_frame_q;
  logic [CW-1:0] miss_q;

  assign frame_start = rx_valid & ~in_frame_q;
  assign missed = miss_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame_q <= 1'b0;
      miss_q     <= '0;
    end else begin
      if (rx_valid) in_frame_q <= ~rx_last;
      if (frame_start && !accept) miss_q <= miss_q + 1'b1;
    end
  end
endmodule

// File: rtl/rxd_packer.sv
// Packs frame bytes into words, counts stored bytes, flags overflow.
module rxd_packer
  import rxd_pkg::*;
#(
  parameter int SW = SIZE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          byte_vld,
  input  logic [7:0]    byte_in,
  input  logic [SW-1:0] size,
  output logic          wr_en,
  output logic [SW-3:0] wr_idx,
  output logic [DW-1:0] wr_data,
  output logic [SW-1:0] count,
  output logic          err
);
  logic [SW-1:0] cnt_q, cnt_eff;
  logic [DW-1:0] asm_q, asm_eff, base_w;
  logic          err_q, err_eff, fits;
  logic [1:0]    lane;

  assign cnt_eff = start ? '0 : cnt_q;
  assign asm_eff = start ? '0 : asm_q;
  assign err_eff = start ? 1'b0 : err_q;
  assign fits    = cnt_eff < size;
  assign lane    = cnt_eff[1:0];
  assign base_w  = (lane == 2'd0) ? '0 : asm_eff;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign wr_data[8*l +: 8] = (lane == 2'(l)) ? byte_in : base_w[8*l +: 8];
  end

  assign wr_en  = byte_vld & fits;
  assign wr_idx = cnt_eff[SW-1:2];
  assign count  = cnt_q;
  assign err    = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      asm_q <= '0;
      err_q <= 1'b0;
    end else if (byte_vld) begin
      if (fits) begin
        cnt_q <= cnt_eff + 1'b1;
        asm_q <= wr_data;
        err_q <= err_eff;
      end else begin
        cnt_q <= cnt_eff;
        asm_q <= asm_eff;
        err_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxd_ctrl.sv
// Descriptor fetch / close sequencer and memory port owner.
module rxd_ctrl
  import rxd_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              poll,
  input  logic [AW-1:0]     base,
  input  logic              frame_start,
  input  logic              rx_valid,
  input  logic              rx_last,
  input  logic              pk_wr_en,
  input  logic [SIZE_W-3:0] pk_wr_idx,
  input  logic [DW-1:0]     pk_wr_data,
  input  logic [SIZE_W-1:0] pk_count,
  input  logic              pk_err,
  input  logic [DW-1:0]     mem_rdata,
  output logic              accept,
  output logic              body,
  output logic [SIZE_W-1:0] buf_size,
  output logic [2:0]        state,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata
);
  localparam int FC_W = 3;
  localparam logic [FC_W-1:0] FC_LAST = FC_W'(DESC_WORDS + 1);

  rx_state_e st_q, st_d;
  logic [FC_W-1:0] fcnt_q;
  logic [AW-1:0]   cur_q, buf_q, nxt_q;
  logic [SIZE_W-1:0] size_q;
  logic            own_q, chain_q, eor_q;
  logic            men_d, mwe_d;
  logic [AW-1:0]   maddr_d;
  logic [DW-1:0]   mwd_d, status_w;
  logic            unused_bits;

  assign unused_bits = ^{mem_rdata[DW-1:AW]};

  assign accept   = (st_q == ST_WAIT) & run;
  assign body     = (st_q == ST_WRITE);
  assign buf_size = size_q;
  assign state    = st_q;

  always_comb begin
    status_w = '0;
    status_w[LEN_LSB +: LEN_W] = LEN_W'(pk_count);
    status_w[ERR_BIT]   = pk_err;
    status_w[FIRST_BIT] = 1'b1;
    status_w[LAST_BIT]  = 1'b1;
  end

  always_comb begin
    st_d    = st_q;
    men_d   = 1'b0;
    mwe_d   = 1'b0;
    maddr_d = mem_addr;
    mwd_d   = mem_wdata;
    case (st_q)
      ST_STOP: if (run) st_d = ST_FETCH;
      ST_FETCH: begin
        if (!run) st_d = ST_STOP;
        else begin
          if (fcnt_q < FC_W'(DESC_WORDS)) begin
            men_d   = 1'b1;
            maddr_d = cur_q + AW'(fcnt_q);
          end
          if (fcnt_q == FC_LAST) st_d = own_q ? ST_WAIT : ST_SUSP;
        end
      end
      ST_SUSP: begin
        if (!run) st_d = ST_STOP;
        else if (poll) st_d = ST_FETCH;
      end
      ST_WAIT: begin
        if (!run) st_d = ST_STOP;
        else if (frame_start) st_d = rx_last ? ST_CLOSE : ST_WRITE;
      end
      ST_WRITE: if (rx_valid && rx_last) st_d = ST_CLOSE;
      ST_CLOSE: begin
        men_d   = 1'b1;
        mwe_d   = 1'b1;
        maddr_d = cur_q;
        mwd_d   = status_w;
        st_d    = run ? ST_FETCH : ST_STOP;
      end
      default: st_d = ST_STOP;
    endcase
    if (pk_wr_en) begin
      men_d   = 1'b1;
      mwe_d   = 1'b1;
      maddr_d = buf_q + AW'(pk_wr_idx);
      mwd_d   = pk_wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_STOP;
      fcnt_q    <= '0;
      cur_q     <= '0;
      buf_q     <= '0;
      nxt_q     <= '0;
      size_q    <= '0;
      own_q     <= 1'b0;
      chain_q   <= 1'b0;
      eor_q     <= 1'b0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      st_q      <= st_d;
      mem_en    <= men_d;
      mem_we    <= mwe_d;
      mem_addr  <= maddr_d;
      mem_wdata <= mwd_d;
      if (st_q == ST_STOP && st_d == ST_FETCH) cur_q <= base;
      if (st_q == ST_CLOSE)
        cur_q <= eor_q ? base : (chain_q ? nxt_q : cur_q + AW'(DESC_WORDS));
      if (st_d == ST_FETCH && st_q != ST_FETCH) fcnt_q <= '0;
      else if (st_q == ST_FETCH) fcnt_q <= fcnt_q + 1'b1;
      if (st_q == ST_FETCH) begin
        case (fcnt_q)
          3'd2: own_q <= mem_rdata[OWN_BIT];
          3'd3: begin
            size_q  <= mem_rdata[SIZE_W-1:0];
            chain_q <= mem_rdata[CHAIN_BIT];
            eor_q   <= mem_rdata[EOR_BIT];
          end
          3'd4: buf_q <= mem_rdata[AW-1:0];
          3'd5: nxt_q <= mem_rdata[AW-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxd_dma.sv
module rxd_dma
  import rxd_pkg::*;
#(
  parameter int AW = 12,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ring_base,
  input  logic          run,
  input  logic          poll,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic [2:0]    dma_state,
  output logic [CW-1:0] missed_cnt
);
  logic              frame_start, accept, body;
  logic              pk_wr_en, pk_err;
  logic [SIZE_W-3:0] pk_wr_idx;
  logic [DW-1:0]     pk_wr_data;
  logic [SIZE_W-1:0] pk_count, buf_size;

  rxd_ingress #(.CW(CW)) ingress_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_last(rx_last),
    .accept(accept), .frame_start(frame_start), .missed(missed_cnt)
  );

  rxd_packer #(.SW(SIZE_W)) packer_i (
    .clk(clk), .rst(rst),
    .start(frame_start & accept),
    .byte_vld(rx_valid & ((frame_start & accept) | body)),
    .byte_in(rx_data), .size(buf_size),
    .wr_en(pk_wr_en), .wr_idx(pk_wr_idx), .wr_data(pk_wr_data),
    .count(pk_count), .err(pk_err)
  );

  rxd_ctrl #(.AW(AW)) ctrl_i (
    .clk(clk), .rst(rst), .run(run), .poll(poll), .base(ring_base),
    .frame_start(frame_start), .rx_valid(rx_valid), .rx_last(rx_last),
    .pk_wr_en(pk_wr_en), .pk_wr_idx(pk_wr_idx), .pk_wr_data(pk_wr_data),
    .pk_count(pk_count), .pk_err(pk_err), .mem_rdata(mem_rdata),
    .accept(accept), .body(body), .buf_size(buf_size), .state(dma_state),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/rxd_dma_chk.sv
module rxd_dma_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic          poll,
  input logic          rx_valid,
  input logic          mem_en,
  input logic          mem_we,
  input logic [31:0]   mem_wdata,
  input logic [2:0]    dma_state,
  input logic [CW-1:0] missed_cnt
);
  // R10
  legal_state_chk: assert property (@(posedge clk) disable iff (rst)
    dma_state inside {3'd0, 3'd1, 3'd3, 3'd4, 3'd5, 3'd7});

  // R5
  close_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_state == 3'd5) |=> (mem_en && mem_we && !mem_wdata[31] && mem_wdata[9] && mem_wdata[8]));

  // R3
  susp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_state == 3'd4 && run && !poll) |=> (dma_state == 3'd4));

  // R3
  idle_port_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_state == 3'd4 || dma_state == 3'd0) |=> !mem_en);

  // R8
  miss_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (missed_cnt == $past(missed_cnt) || missed_cnt == $past(missed_cnt) + 1'b1));

  // R2
  stop_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && (dma_state == 3'd3 || dma_state == 3'd4)) |=> (dma_state == 3'd0));

  // R9
  wait_poll_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_state == 3'd3 && run && poll && !rx_valid) |=> (dma_state == 3'd3));
endmodule

bind rxd_dma rxd_dma_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst(rst), .run(run), .poll(poll), .rx_valid(rx_valid),
  .mem_en(mem_en), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .dma_state(dma_state), .missed_cnt(missed_cnt)
);

// File: tb/rxd_dma_tb_top.sv
`timescale 1ns/1ps
module rxd_dma_tb_top;
  localparam int AW = 12;
  localparam int CW = 8;
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] ring_base = 12'h100;
  logic run = 1'b0, poll = 1'b0;
  logic rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [2:0] dma_state;
  logic [CW-1:0] missed_cnt;

  logic [31:0] mem [0:(1<<AW)-1];
  logic [7:0]  fbytes [0:127];
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  int daddr [3] = '{32'h100, 32'h140, 32'h144};
  int dbuf  [3] = '{32'h200, 32'h300, 32'h400};
  int dsize [3] = '{10, 64, 8};

  always #2.5 clk = ~clk;

  rxd_dma #(.AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .ring_base(ring_base), .run(run), .poll(poll),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dma_state(dma_state), .missed_cnt(missed_cnt)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else mem_rdata <= mem[mem_addr];
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(int stored, int wi);
    logic [31:0] w = '0;
    for (int j = 0; j < 4; j++)
      if (4*wi + j < stored) w[8*j +: 8] = fbytes[4*wi + j];
    return w;
  endfunction

  function automatic logic [31:0] exp_status(int stored, bit err);
    logic [31:0] s = '0;
    s[29:16] = 14'(stored);
    s[15] = err;
    s[9] = 1'b1;
    s[8] = 1'b1;
    return s;
  endfunction

  task automatic arm(int d);
    for (int w = 0; w < (dsize[d] + 3) / 4 + 1; w++) mem[dbuf[d] + w] = SENT;
    mem[daddr[d]] = 32'h8000_0000;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(int len, bit poll_first);
    for (int i = 0; i < len; i++) fbytes[i] = 8'($urandom);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = fbytes[i];
      rx_last  = (i == len - 1);
      poll     = poll_first && (i == 0);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; poll = 1'b0;
    wait_n(14);
  endtask

  task automatic check_frame(int d, int len);
    int stored = (len < dsize[d]) ? len : dsize[d];
    bit err = (len > dsize[d]);
    int nw = (stored + 3) / 4;
    chk(err ? "R6 status" : "R5 status", mem[daddr[d]], exp_status(stored, err));
    for (int w = 0; w < (dsize[d] + 3) / 4 + 1; w++)
      chk(err ? "R6 buffer" : "R4 buffer", mem[dbuf[d] + w],
          (w < nw) ? exp_word(stored, w) : SENT);
  endtask

  initial begin
    logic [31:0] saved;
    int idx;
    void'($urandom(32'd2024));
    for (int a = 0; a < (1 << AW); a++) mem[a] = 32'h0;
    mem_rdata = '0;
    // ring: D0 chained to D1, D1 plain (next = +4), D2 end of ring
    mem[daddr[0] + 1] = 32'h0000_4000 | 32'(dsize[0]);
    mem[daddr[0] + 2] = 32'(dbuf[0]);
    mem[daddr[0] + 3] = 32'(daddr[1]);
    mem[daddr[1] + 1] = 32'(dsize[1]);
    mem[daddr[1] + 2] = 32'(dbuf[1]);
    mem[daddr[1] + 3] = 32'h180;
    mem[daddr[2] + 1] = 32'h0000_8000 | 32'(dsize[2]);
    mem[daddr[2] + 2] = 32'(dbuf[2]);
    mem[daddr[2] + 3] = 32'h0;
    for (int d = 0; d < 3; d++) arm(d);

    wait_n(4);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 state", 32'(dma_state), 0);
    chk("R1 missed", 32'(missed_cnt), 0);
    chk("R1 mem_en", 32'(mem_en), 0);

    run = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R2 fetching", 32'(dma_state), 1);
    wait_n(10);
    chk("R4 waiting", 32'(dma_state), 3);

    send_frame(7, 1'b0);
    check_frame(0, 7);
    send_frame(20, 1'b0);
    check_frame(1, 20);          // R7 chained D0 -> D1
    send_frame(13, 1'b0);
    check_frame(2, 13);          // R7 D1 -> D1+4 (not word 3)
    chk("R3 suspend after end-of-ring wrap (R7)", 32'(dma_state), 4);

    poll = 1'b1; @(negedge clk); poll = 1'b0;
    wait_n(12);
    chk("R3 still suspended", 32'(dma_state), 4);
    chk("R3 status kept", mem[daddr[0]], exp_status(7, 1'b0));

    saved = mem[dbuf[0]];
    send_frame(5, 1'b0);
    chk("R8 missed while suspended", 32'(missed_cnt), 1);
    chk("R8 buffer untouched", mem[dbuf[0]], saved);

    arm(1); arm(2); arm(0);
    poll = 1'b1; @(negedge clk); poll = 1'b0;
    wait_n(12);
    chk("R3 resume on poll", 32'(dma_state), 3);

    begin
      int busy = 0;
      poll = 1'b1; @(negedge clk); poll = 1'b0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (mem_en || dma_state != 3'd3) busy++;
      end
      chk("R9 poll ignored while waiting", 32'(busy), 0);
    end

    idx = 0;
    for (int it = 0; it < 25; it++) begin
      int len = 1 + int'($urandom % (dsize[idx] + 5));
      send_frame(len, ($urandom % 3) == 0);
      check_frame(idx, len);
      chk("R7 ring order", 32'(dma_state), 3);
      arm(idx);
      idx = (idx + 1) % 3;
    end

    run = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R2 stopped", 32'(dma_state), 0);
    send_frame(6, 1'b0);
    chk("R8 missed while stopped", 32'(missed_cnt), 2);
    chk("R8 no write while stopped", mem[dbuf[idx]], SENT);

    run = 1'b1;
    wait_n(12);
    chk("R2 restart waiting", 32'(dma_state), 3);
    send_frame(1, 1'b0);
    check_frame(0, 1);           // R2 restart fetches from base

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule